// File: doc/BRIEF.md
# Processor Bus Cycle Definition Sequencer

This block turns internal transfer requests into the cycle-definition signals of a processor-style external bus. A request carries its attributes: byte offset within an 8-byte window, size, read or write, memory or I/O, data or control, cacheable, a lock reason code and a keep-lock flag. The block accepts the request, issues an address strobe for one clock, and drives the cycle-type outputs from that clock onward. It holds them valid until the clock after the earlier of two events: next-address sampled low during the data phase, or the final ready of the cycle. It counts ready beats to find the end of each cycle. A cacheable read becomes a four-beat line fill when the line-enable input is low at its first ready. A cacheable write is always a four-beat line write.

The bus lock output spans whole locked sequences. Lock reason codes pass through a configuration filter. A locked access that crosses an 8-byte boundary is issued as two back-to-back address phases, each marked as split, with the lock held between them. A bus hold request is granted only on an idle, unlocked bus. While the hold is granted, every cycle-type output is floated through a shared output enable.

The controller has four states. ST_IDLE waits for a request or a hold. ST_ADDR drives the address strobe. ST_DATA counts ready beats. ST_HOLD grants the bus to another master. The transitions are:
- ST_IDLE to ST_HOLD on a grantable hold.
- ST_IDLE to ST_ADDR on an accepted request.
- ST_ADDR to ST_DATA always.
- ST_DATA to ST_ADDR on the final beat of the first half of a split access.
- ST_DATA to ST_IDLE on any other final beat.
- ST_HOLD to ST_IDLE when the hold is removed.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, addr_strobe_n=1, hold_ack=0, cyc_oe=1, cyc_lock_n=1, burst_active=0, and the definition outputs show their idle values (cyc_cacheable_n=1, cyc_data=0, cyc_mem=0, cyc_write=0, cyc_split=0).
- R2: The address strobe behaves as follows:
  - A request is accepted on a clock edge where req_valid and req_ready are both high.
  - In the next clock, addr_strobe_n is low for exactly one clock.
  - In that clock, the outputs carry the request's attributes: cyc_cacheable_n = not cacheable, cyc_data = data, cyc_mem = memory, cyc_write = write.
- R3: The definition outputs keep their values until one of two events is sampled at a clock edge in the data phase: next_addr_n low, or the final rdy_n low of the cycle. Whichever comes first, from the following clock the outputs return to their idle values.
- R4: A cacheable read becomes a 4-beat line fill if line_en_n is low at its first rdy_n beat; otherwise it ends on that first beat. burst_active is high from the clock after the first beat until the final beat of a line fill.
- R5: line_en_n is ignored at every other time, and a non-cacheable read ends on its first beat whatever line_en_n is.
- R6: A cacheable write is always a 4-beat burst, whatever line_en_n is.
- R7: Lock reason codes are: 0 none, 1 lock prefix, 2 descriptor update, 3 page table, 4 interrupt acknowledge, 5 exchange. With cfg_nolock=0, codes 1 to 5 lock the cycle (cyc_lock_n=0). With cfg_nolock=1, only codes 3 and 4 lock it.
- R8: A locked access whose offset plus size (size = bytes-1) exceeds 7 is issued as two address phases, both with cyc_split=1. cyc_lock_n stays low between them. Unlocked accesses never assert cyc_split and are issued once.
- R9: The lock is released in the clock after the final beat of a locked access unless req_lock_keep was set. With req_lock_keep set, the lock is held through idle into the next request, which is then locked whatever its reason code.
- R10: Bus hold is handled as follows:
  - hold_req is granted only in ST_IDLE with the lock released.
  - hold_ack rises the clock after the grant and falls the clock after hold_req is removed.
  - cyc_oe=0 exactly while hold_ack is high.
- R11: A grantable hold_req takes priority over a pending request. req_ready is low, and no address strobe is issued while the hold is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_offset | input | ALIGN_BITS | Byte offset within the 8-byte window |
| req_size | input | SIZE_W | Transfer size in bytes minus one |
| req_write | input | 1 | 1 = write |
| req_mem | input | 1 | 1 = memory, 0 = I/O or special |
| req_data | input | 1 | 1 = data, 0 = control |
| req_cacheable | input | 1 | Cacheable read or line write |
| req_lock_why | input | 3 | Lock reason code |
| req_lock_keep | input | 1 | Keep lock after this access |
| cfg_nolock | input | 1 | Restrict locking to page table and interrupt acknowledge |
| rdy_n | input | 1 | Data beat ready, active low |
| next_addr_n | input | 1 | Next address request, active low |
| line_en_n | input | 1 | Line fill enable, active low |
| hold_req | input | 1 | Bus hold request |
| hold_ack | output | 1 | Bus hold acknowledge |
| addr_strobe_n | output | 1 | Address strobe, active low |
| cyc_oe | output | 1 | Output enable of all cycle-type outputs |
| cyc_cacheable_n | output | 1 | Cacheable cycle, active low |
| cyc_data | output | 1 | Data (1) or control (0) |
| cyc_mem | output | 1 | Memory (1) or I/O (0) |
| cyc_write | output | 1 | Write (1) or read (0) |
| cyc_lock_n | output | 1 | Bus lock, active low |
| cyc_split | output | 1 | Part of a misaligned locked access |
| burst_active | output | 1 | Line burst in progress |

## Verification
The assertions assume that the system returns rdy_n and next_addr_n only during a data phase, and that hold_req does not make the block grant a hold while a sequence is still locked. The bench keeps within these assumptions:
- It drives rdy_n and next_addr_n only after the address strobe has been seen, and idles them between transfers.
- It raises hold_req only between transfers.
- It respects the lock it models itself, so a granted hold never meets a held lock.

Random transfers vary size, offset, lock reason, filter bit, wait states and next-address timing. Directed cases cover the line fill decision, split locking and hold blocking.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;

    typedef enum logic [2:0] {
        LK_NONE   = 3'd0,
        LK_PREFIX = 3'd1,
        LK_DESC   = 3'd2,
        LK_PTAB   = 3'd3,
        LK_INTA   = 3'd4,
        LK_XCHG   = 3'd5
    } lock_why_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_HOLD = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic write;
        logic mem;
        logic data;
        logic cacheable;
        logic split;
    } cyc_attr_t;

endpackage

// File: rtl/bcs_lock_filter.sv
`timescale 1ns/1ps
module bcs_lock_filter
    import bcs_pkg::*;
(
    input  logic [2:0] why,
    input  logic       nolock,
    output logic       lock_req
);
    lock_why_e why_e;

    always_comb begin
        why_e = lock_why_e'(why);
        case (why_e)
            LK_PTAB, LK_INTA:           lock_req = 1'b1;
            LK_PREFIX, LK_DESC, LK_XCHG: lock_req = !nolock;
            default:                    lock_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcs_split_detect.sv
`timescale 1ns/1ps
module bcs_split_detect #(
    parameter int ALIGN_BITS = 3,
    parameter int SIZE_W     = 3
) (
    input  logic [ALIGN_BITS-1:0] offset,
    input  logic [SIZE_W-1:0]     size,
    output logic                  crosses
);
    localparam int SUMW = ((ALIGN_BITS > SIZE_W) ? ALIGN_BITS : SIZE_W) + 1;
    localparam logic [SUMW-1:0] LAST_BYTE = SUMW'((1 << ALIGN_BITS) - 1);

    logic [SUMW-1:0] end_byte;

    always_comb begin
        end_byte = SUMW'(offset) + SUMW'(size);
        crosses  = end_byte > LAST_BYTE;
    end
endmodule

// File: rtl/bcs_beat_ctr.sv
`timescale 1ns/1ps
module bcs_beat_ctr #(
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic first_beat,
    output logic final_slot
);
    localparam int CW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [CW-1:0] TOP = CW'(BURST_LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
        end
    end

    assign first_beat = (cnt_q == '0);
    assign final_slot = (cnt_q == TOP);
endmodule

// File: rtl/bus_cycle_seq.sv
`timescale 1ns/1ps
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int SIZE_W     = 3,
    parameter int ALIGN_BITS = 3,
    parameter int BURST_LEN  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ALIGN_BITS-1:0] req_offset,
    input  logic [SIZE_W-1:0]     req_size,
    input  logic                  req_write,
    input  logic                  req_mem,
    input  logic                  req_data,
    input  logic                  req_cacheable,
    input  logic [2:0]            req_lock_why,
    input  logic                  req_lock_keep,
    input  logic                  cfg_nolock,
    input  logic                  rdy_n,
    input  logic                  next_addr_n,
    input  logic                  line_en_n,
    input  logic                  hold_req,
    output logic                  hold_ack,
    output logic                  addr_strobe_n,
    output logic                  cyc_oe,
    output logic                  cyc_cacheable_n,
    output logic                  cyc_data,
    output logic                  cyc_mem,
    output logic                  cyc_write,
    output logic                  cyc_lock_n,
    output logic                  cyc_split,
    output logic                  burst_active
);
    seq_state_e state_q, state_d;
    cyc_attr_t  attr_q;
    logic       lock_held_q;
    logic       keep_q;
    logic       split_rem_q;
    logic       defs_live_q;
    logic       burst_q;

    logic lock_req, crosses, lock_now;
    logic hold_ok, accept, beat, burst_pick, last_beat;
    logic first_beat, final_slot;
    logic defs_on;

    bcs_lock_filter u_lock (
        .why      (req_lock_why),
        .nolock   (cfg_nolock),
        .lock_req (lock_req)
    );

    bcs_split_detect #(
        .ALIGN_BITS (ALIGN_BITS),
        .SIZE_W     (SIZE_W)
    ) u_split (
        .offset  (req_offset),
        .size    (req_size),
        .crosses (crosses)
    );

    bcs_beat_ctr #(
        .BURST_LEN (BURST_LEN)
    ) u_beats (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (state_q == ST_ADDR),
        .step       (beat),
        .first_beat (first_beat),
        .final_slot (final_slot)
    );

    // Handshake and beat qualifiers
    always_comb begin
        lock_now   = lock_held_q | lock_req;
        hold_ok    = hold_req && !lock_held_q;
        req_ready  = (state_q == ST_IDLE) && !hold_ok;
        accept     = req_ready && req_valid;
        beat       = (state_q == ST_DATA) && !rdy_n;
        burst_pick = attr_q.cacheable && (attr_q.write || !line_en_n);
        last_beat  = beat && (first_beat ? !burst_pick : final_slot);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hold_ok)     state_d = ST_HOLD;
                else if (accept) state_d = ST_ADDR;
            end
            ST_ADDR: state_d = ST_DATA;
            ST_DATA: begin
                if (last_beat) state_d = split_rem_q ? ST_ADDR : ST_IDLE;
            end
            ST_HOLD: begin
                if (!hold_req) state_d = ST_IDLE;
            end
        endcase
    end

    // State register and the attributes it carries
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            attr_q      <= '0;
            lock_held_q <= 1'b0;
            keep_q      <= 1'b0;
            split_rem_q <= 1'b0;
            defs_live_q <= 1'b0;
            burst_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                attr_q.write     <= req_write;
                attr_q.mem       <= req_mem;
                attr_q.data      <= req_data;
                attr_q.cacheable <= req_cacheable;
                attr_q.split     <= lock_now & crosses;
                lock_held_q      <= lock_now;
                keep_q           <= req_lock_keep & lock_now;
                split_rem_q      <= lock_now & crosses;
            end
            if (state_q == ST_ADDR) begin
                defs_live_q <= 1'b1;
                burst_q     <= 1'b0;
            end
            if (state_q == ST_DATA) begin
                if (!next_addr_n) defs_live_q <= 1'b0;
                if (beat && first_beat) burst_q <= burst_pick;
                if (last_beat) begin
                    defs_live_q <= 1'b0;
                    if (split_rem_q) split_rem_q <= 1'b0;
                    else             lock_held_q <= keep_q;
                end
            end
        end
    end

    // Outputs from registered state only
    always_comb begin
        defs_on         = (state_q == ST_ADDR) || ((state_q == ST_DATA) && defs_live_q);
        addr_strobe_n   = !(state_q == ST_ADDR);
        hold_ack        = (state_q == ST_HOLD);
        cyc_oe          = (state_q != ST_HOLD);
        cyc_cacheable_n = defs_on ? !attr_q.cacheable : 1'b1;
        cyc_data        = defs_on & attr_q.data;
        cyc_mem         = defs_on & attr_q.mem;
        cyc_write       = defs_on & attr_q.write;
        cyc_split       = defs_on & attr_q.split;
        cyc_lock_n      = !lock_held_q;
        burst_active    = (state_q == ST_DATA) && burst_q;
    end
endmodule

// File: rtl/bcs_checks.sv
`timescale 1ns/1ps
module bcs_checks (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic hold_ack,
    input logic addr_strobe_n,
    input logic cyc_oe,
    input logic cyc_cacheable_n,
    input logic cyc_data,
    input logic cyc_mem,
    input logic cyc_write,
    input logic cyc_lock_n,
    input logic cyc_split,
    input logic burst_active
);
    a_r2_strobe_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_strobe_n |=> addr_strobe_n);

    a_r3_defs_hold_into_data: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_strobe_n |=> ($stable(cyc_write) && $stable(cyc_mem) &&
                            $stable(cyc_data) && $stable(cyc_cacheable_n)));

    a_r4_burst_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        burst_active |-> (addr_strobe_n && !hold_ack));

    a_r8_split_locked: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_split |-> !cyc_lock_n);

    a_r10_float_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (!cyc_oe && cyc_lock_n));

    a_r10_grant_unlocked_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> ($past(cyc_lock_n) && $past(addr_strobe_n) && !$past(burst_active)));

    a_r11_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (!req_ready && addr_strobe_n));
endmodule

bind bus_cycle_seq bcs_checks u_bcs_checks (.*);

// File: tb/tb_bus_cycle_seq.sv
`timescale 1ns/1ps
module tb_bus_cycle_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_offset = '0;
    logic [2:0] req_size = '0;
    logic       req_write = 1'b0, req_mem = 1'b0, req_data = 1'b0, req_cacheable = 1'b0;
    logic [2:0] req_lock_why = '0;
    logic       req_lock_keep = 1'b0, cfg_nolock = 1'b0;
    logic       rdy_n = 1'b1, next_addr_n = 1'b1, line_en_n = 1'b1, hold_req = 1'b0;
    logic       hold_ack, addr_strobe_n, cyc_oe, cyc_cacheable_n, cyc_data, cyc_mem;
    logic       cyc_write, cyc_lock_n, cyc_split, burst_active;

    int tests = 0;
    int fails = 0;
    bit held = 1'b0;

    always #4 clk = !clk;

    bus_cycle_seq dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit filt(input logic [2:0] why, input bit nolock);
        if (nolock) return (why == 3'd3) || (why == 3'd4);
        return (why >= 3'd1) && (why <= 3'd5);
    endfunction

    function automatic bit crosses(input logic [2:0] off, input logic [2:0] sz);
        return (int'(off) + int'(sz)) > 7;
    endfunction

    task automatic chk_idle_defs(input string tag);
        chk(cyc_cacheable_n == 1'b1 && !cyc_data && !cyc_mem && !cyc_write && !cyc_split,
            tag, int'({cyc_cacheable_n, cyc_data, cyc_mem, cyc_write, cyc_split}), 16);
    endtask

    task automatic chk_live_defs(input string tag, input bit w, m, d, c, s);
        chk(cyc_cacheable_n == !c && cyc_data == d && cyc_mem == m && cyc_write == w && cyc_split == s,
            tag, int'({cyc_cacheable_n, cyc_data, cyc_mem, cyc_write, cyc_split}),
            int'({!c, d, m, w, s}));
    endtask

    // Entered and left just after a falling edge.
    task automatic xfer(input bit w, m, d, c, input logic [2:0] why, input logic [2:0] off,
                        input logic [2:0] sz, input bit keep, input bit nolock,
                        input bit ken_first, input int waits, input int na_at);
        bit locked, split, na_seen;
        int nb, beats, ci;
        locked = held | filt(why, nolock);
        split  = locked & crosses(off, sz);
        nb     = (c && (w || !ken_first)) ? 4 : 1;
        req_write = w; req_mem = m; req_data = d; req_cacheable = c;
        req_lock_why = why; req_offset = off; req_size = sz;
        req_lock_keep = keep; cfg_nolock = nolock; req_valid = 1'b1;
        #1 chk(req_ready == 1'b1, "R2 ready", int'(req_ready), 1);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        for (int h = 0; h < (split ? 2 : 1); h++) begin
            chk(addr_strobe_n == 1'b0, "R2 strobe", int'(addr_strobe_n), 0);
            chk_live_defs("R2 attrs", w, m, d, c, split);
            chk(cyc_split == split, "R8 split", int'(cyc_split), int'(split));
            chk(cyc_lock_n == !locked, "R7 lock", int'(cyc_lock_n), int'(!locked));
            @(posedge clk); @(negedge clk);
            na_seen = 1'b0; beats = 0; ci = 0;
            while (beats < nb) begin
                chk(addr_strobe_n == 1'b1, "R2 strobe high", int'(addr_strobe_n), 1);
                if (na_seen) chk_idle_defs("R3 released");
                else         chk_live_defs("R3 held", w, m, d, c, split);
                chk(burst_active == (beats > 0 && nb == 4), "R4 burst flag",
                    int'(burst_active), int'(beats > 0 && nb == 4));
                if (locked) chk(cyc_lock_n == 1'b0, "R8 lock during data", int'(cyc_lock_n), 0);
                rdy_n       = (ci >= waits) ? 1'b0 : 1'b1;
                next_addr_n = (ci + 1 == na_at) ? 1'b0 : 1'b1;
                line_en_n   = (beats == 0 && rdy_n == 1'b0) ? ken_first : 1'($urandom % 2);
                @(posedge clk);
                if (!next_addr_n) na_seen = 1'b1;
                if (!rdy_n) beats++;
                ci++;
                @(negedge clk);
            end
            rdy_n = 1'b1; next_addr_n = 1'b1; line_en_n = 1'b1;
        end
        held = keep & locked;
        chk(cyc_lock_n == !held, "R9 lock after end", int'(cyc_lock_n), int'(!held));
        chk(addr_strobe_n == 1'b1, "R3 no strobe after end", int'(addr_strobe_n), 1);
        chk(burst_active == 1'b0, "R4 burst cleared", int'(burst_active), 0);
        chk_idle_defs("R3 idle after end");
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(addr_strobe_n == 1'b1, "R1 strobe", int'(addr_strobe_n), 1);
        chk(hold_ack == 1'b0 && cyc_oe == 1'b1, "R1 hold/oe", int'({hold_ack, cyc_oe}), 1);
        chk(cyc_lock_n == 1'b1 && burst_active == 1'b0, "R1 lock/burst",
            int'({cyc_lock_n, burst_active}), 2);
        chk_idle_defs("R1 defs");
        rst_n = 1'b1;
        @(negedge clk);

        // R5: non-cacheable read ignores line_en_n
        xfer(0, 1, 1, 0, 3'd0, 3'd0, 3'd3, 0, 0, 1'b0, 1, 0);
        // R4: cacheable read with line enable -> fill, without -> single
        xfer(0, 1, 1, 1, 3'd0, 3'd0, 3'd7, 0, 0, 1'b0, 0, 0);
        xfer(0, 1, 0, 1, 3'd0, 3'd0, 3'd7, 0, 0, 1'b1, 2, 0);
        // R6: cacheable write always bursts
        xfer(1, 1, 1, 1, 3'd0, 3'd0, 3'd7, 0, 0, 1'b1, 0, 0);
        // R8: locked misaligned splits; unlocked misaligned does not
        xfer(0, 1, 1, 0, 3'd1, 3'd6, 3'd3, 0, 0, 1'b1, 1, 0);
        xfer(1, 1, 1, 0, 3'd0, 3'd6, 3'd3, 0, 0, 1'b1, 0, 0);
        // R7: filter bit drops prefix lock, keeps page table lock
        xfer(1, 1, 1, 0, 3'd1, 3'd0, 3'd1, 0, 1, 1'b1, 0, 0);
        xfer(0, 1, 0, 0, 3'd3, 3'd0, 3'd1, 0, 1, 1'b1, 0, 0);
        // R3: early next address releases definitions
        xfer(0, 0, 1, 0, 3'd0, 3'd0, 3'd0, 0, 0, 1'b1, 2, 1);
        xfer(0, 1, 1, 1, 3'd0, 3'd0, 3'd7, 0, 0, 1'b0, 0, 2);

        // R10/R11: hold on idle unlocked bus beats a pending request
        hold_req = 1'b1; req_valid = 1'b1;
        #1 chk(req_ready == 1'b0, "R11 ready low", int'(req_ready), 0);
        @(posedge clk); @(negedge clk);
        chk(hold_ack == 1'b1, "R10 ack", int'(hold_ack), 1);
        chk(cyc_oe == 1'b0, "R10 float", int'(cyc_oe), 0);
        @(posedge clk); @(negedge clk);
        chk(addr_strobe_n == 1'b1, "R11 no strobe", int'(addr_strobe_n), 1);
        req_valid = 1'b0; hold_req = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(hold_ack == 1'b0 && cyc_oe == 1'b1, "R10 release", int'({hold_ack, cyc_oe}), 1);

        // R9/R10: kept lock blocks hold until the last locked access ends
        xfer(0, 1, 1, 0, 3'd5, 3'd0, 3'd3, 1, 0, 1'b1, 0, 0);
        hold_req = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        chk(hold_ack == 1'b0, "R10 blocked by lock", int'(hold_ack), 0);
        chk(cyc_lock_n == 1'b0, "R9 lock kept in idle", int'(cyc_lock_n), 0);
        xfer(1, 1, 1, 0, 3'd0, 3'd0, 3'd3, 0, 0, 1'b1, 1, 0);
        chk(hold_ack == 1'b0, "R10 ack not yet", int'(hold_ack), 0);
        @(posedge clk); @(negedge clk);
        chk(hold_ack == 1'b1, "R10 ack after unlock", int'(hold_ack), 1);
        hold_req = 1'b0;
        @(posedge clk); @(negedge clk);

        // Random mix
        for (int n = 0; n < 60; n++) begin
            xfer(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
                 3'($urandom % 6), 3'($urandom % 8), 3'($urandom % 8),
                 ($urandom % 4) == 0, 1'($urandom % 2), 1'($urandom % 2),
                 int'($urandom % 3), int'($urandom % 4));
            if (($urandom % 3) == 0) begin
                @(posedge clk); @(negedge clk);
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule